// File: doc/BRIEF.md
# Floppy Drive Control Output Register

This block is the host-facing drive control register of a floppy disk controller. It decodes a single I/O address on a simple synchronous register bus, where the default address is 0x3F2. The register can be written at any time and read back at any time. Its contents are turned into registered pin controls:

- active-low drive selects;
- active-low motor enables;
- a reset line for the controller core;
- output-enable and input-honour strobes for the DMA request, interrupt, DMA acknowledge and terminal-count pins.

The software reset is level-held. It stays asserted for as long as the reset bit in the register reads 0. A stretch counter then keeps the reset asserted for a minimum time, so a 0-then-1 write pair in consecutive bus cycles still gives a valid reset pulse. The software reset never changes the register itself.

How the DMA and interrupt pins are gated depends on a mode input. In the AT-compatible mode, the DMA enable bit controls the gating. In the PS/2-style mode, the gating is always open, including while a hardware reset is applied.

Top module: `fdc_out_ctl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls: the register reads 0x00, `fdc_reset` is 1, `ds_n` selects drive 0 (ds_n = 2'b10), and `mtr_n` is all ones.
- R2: A write strobe at `BASE_ADDR` stores `bus_wdata`. A read strobe at `BASE_ADDR` returns the register on `bus_rdata` one clock later. Bits 7:6 always read 0. At all other times `bus_rdata` is 0x00.
- R3: Writes to any address other than `BASE_ADDR` leave the register and every output unchanged.
- R4: Bits 1:0 are a binary drive code. Code 0 drives ds_n = 2'b10, code 1 drives ds_n = 2'b01, and codes 2 and 3 drive ds_n = 2'b11. Outputs follow a register change one clock later.
- R5: Bit 4 set drives `mtr_n[0]` low and bit 5 set drives `mtr_n[1]` low. Writing 0x1C gives ds_n = 2'b10 and mtr_n = 2'b10. Writing 0x2D gives ds_n = 2'b01 and mtr_n = 2'b01.
- R6: When bit 2 of the register is 0, `fdc_reset` is 1 on the next clock. It stays 1 until bit 2 is written to 1, and it returns to 0 after the stretch time.
- R7: `fdc_reset` stays high for at least HOLD = ceil(MIN_RST_PS / CLK_PS) clocks. A single-cycle 0 on bit 2 gives exactly HOLD+1 high cycles, which is 11 at the default parameters.
- R8: A software reset changes no register bit, and it changes neither the drive-select nor the motor outputs.
- R9: With `ps2_mode` = 0, `drq_oe`, `fintr_oe`, `dack_gate` and `tc_gate` all equal bit 3 of the register. All four are 0 during a hardware reset.
- R10: With `ps2_mode` = 1, all four gating outputs are 1, even during a hardware reset. A hardware reset still clears bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after `bus_rd` |
| ps2_mode | input | 1 | 1 = PS/2-style gating, 0 = AT-compatible gating |
| fdc_reset | output | 1 | Controller core reset, active high |
| ds_n | output | DRIVES | Active-low drive selects |
| mtr_n | output | DRIVES | Active-low motor enables |
| drq_oe | output | 1 | Output enable for the DMA request pin |
| fintr_oe | output | 1 | Output enable for the interrupt pin |
| dack_gate | output | 1 | 1 = DMA acknowledge input is honoured |
| tc_gate | output | 1 | 1 = terminal-count input is honoured |

## Verification
The assertions assume that `rst` is high for at least one clock edge before the first checked cycle. They also assume that `CLK_PS` is the true clock period, because the minimum-width check counts clocks rather than time. `ps2_mode` is treated as a level that may change on any cycle, and the gating checks compare against its value one clock earlier.

The bench starts every run with reset held for several edges. It changes `ps2_mode` and the bus signals only on falling edges. It runs the real stretch check at the default clock parameter, and it sweeps all 256 write values with the mode taken from bit 7 of each value.

// File: rtl/fdc_octl_pkg.sv
package fdc_octl_pkg;

  localparam int SEL_LSB = 0;
  localparam int SEL_W   = 2;
  localparam int SRST_N  = 2;
  localparam int DMA_EN  = 3;
  localparam int MTR_LSB = 4;
  localparam int MAX_DRIVES = 4;

  // Bits that hold state: select, reset, dma enable and one motor bit per drive.
  function automatic logic [7:0] live_mask(input int drives);
    logic [7:0] m;
    m = 8'h0F;
    for (int i = 0; i < MAX_DRIVES; i++)
      if (i < drives) m[MTR_LSB + i] = 1'b1;
    return m;
  endfunction

  function automatic int hold_cycles(input longint clk_ps, input longint min_ps);
    longint c;
    c = (min_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/fdc_octl_regs.sv
module fdc_octl_regs
  import fdc_octl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h03F2,
  parameter int          DRIVES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        ctl_q,
  output logic [7:0]        bus_rdata
);

  localparam logic [7:0]        MASK = live_mask(DRIVES);
  localparam logic [ADDR_W-1:0] HIT  = BASE_ADDR[ADDR_W-1:0];

  logic hit;
  assign hit = (bus_addr == HIT);

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (bus_wr && hit)
      ctl_q <= bus_wdata & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd && hit)
      bus_rdata <= ctl_q;
    else
      bus_rdata <= '0;
  end

endmodule

// File: rtl/fdc_octl_stretch.sv
module fdc_octl_stretch #(
  parameter int HOLD_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic srst_n,
  output logic fdc_reset
);

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= LOAD;
    else if (!srst_n)
      cnt <= LOAD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      fdc_reset <= 1'b1;
    else
      fdc_reset <= !srst_n || (cnt != '0);
  end

endmodule

// File: rtl/fdc_octl_pins.sv
module fdc_octl_pins
  import fdc_octl_pkg::*;
#(
  parameter int DRIVES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps2_mode,
  input  logic [7:0]        ctl_q,
  output logic [DRIVES-1:0] ds_n,
  output logic [DRIVES-1:0] mtr_n,
  output logic              dma_open
);

  logic [SEL_W-1:0] sel;
  assign sel = ctl_q[SEL_LSB +: SEL_W];

  for (genvar i = 0; i < DRIVES; i++) begin : g_drive
    localparam logic [SEL_W-1:0] CODE = SEL_W'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        ds_n[i]  <= (i != 0);
        mtr_n[i] <= 1'b1;
      end else begin
        ds_n[i]  <= (sel != CODE);
        mtr_n[i] <= !ctl_q[MTR_LSB + i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      dma_open <= ps2_mode;
    else
      dma_open <= ps2_mode || ctl_q[DMA_EN];
  end

endmodule

// File: rtl/fdc_out_ctl.sv
module fdc_out_ctl
  import fdc_octl_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE_ADDR  = 16'h03F2,
  parameter int          DRIVES     = 2,
  parameter longint      CLK_PS     = 10000,
  parameter longint      MIN_RST_PS = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ps2_mode,
  output logic              fdc_reset,
  output logic [DRIVES-1:0] ds_n,
  output logic [DRIVES-1:0] mtr_n,
  output logic              drq_oe,
  output logic              fintr_oe,
  output logic              dack_gate,
  output logic              tc_gate
);

  localparam int HOLD_CYC = hold_cycles(CLK_PS, MIN_RST_PS);

  logic [7:0] ctl_q;
  logic       dma_open;

  fdc_octl_regs #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DRIVES(DRIVES)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ctl_q(ctl_q),
    .bus_rdata(bus_rdata)
  );

  fdc_octl_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk(clk), .rst(rst), .srst_n(ctl_q[SRST_N]), .fdc_reset(fdc_reset)
  );

  fdc_octl_pins #(.DRIVES(DRIVES)) u_pins (
    .clk(clk), .rst(rst), .ps2_mode(ps2_mode), .ctl_q(ctl_q),
    .ds_n(ds_n), .mtr_n(mtr_n), .dma_open(dma_open)
  );

  assign drq_oe    = dma_open;
  assign fintr_oe  = dma_open;
  assign dack_gate = dma_open;
  assign tc_gate   = dma_open;

endmodule

// File: rtl/fdc_octl_chk.sv
module fdc_octl_chk
  import fdc_octl_pkg::*;
#(
  parameter int     DRIVES     = 2,
  parameter longint CLK_PS     = 10000,
  parameter longint MIN_RST_PS = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              ps2_mode,
  input logic [7:0]        ctl_q,
  input logic              fdc_reset,
  input logic [DRIVES-1:0] ds_n,
  input logic              drq_oe,
  input logic              fintr_oe,
  input logic              dack_gate,
  input logic              tc_gate,
  input logic [7:0]        bus_rdata
);

  localparam int         HOLD = hold_cycles(CLK_PS, MIN_RST_PS);
  localparam logic [7:0] MASK = live_mask(DRIVES);

  int unsigned hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)
      hi_cnt <= 0;
    else if (fdc_reset)
      hi_cnt <= (hi_cnt < 1000) ? hi_cnt + 1 : hi_cnt;
    else
      hi_cnt <= 0;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctl_q == 8'h00) && fdc_reset);

  assert_rdata_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~MASK) == 8'h00);

  assert_sel_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ds_n));

  assert_rst_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[SRST_N] |=> fdc_reset);

  assert_stretch_min_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fdc_reset) |-> hi_cnt >= HOLD);

  assert_at_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(ps2_mode) && !$past(rst)) |->
      (drq_oe == $past(ctl_q[DMA_EN])) && (tc_gate == $past(ctl_q[DMA_EN])));

  assert_ps2_open_R10: assert property (@(posedge clk) disable iff (rst)
    $past(ps2_mode) |-> drq_oe && fintr_oe && dack_gate && tc_gate);

endmodule

bind fdc_out_ctl fdc_octl_chk #(
  .DRIVES(DRIVES), .CLK_PS(CLK_PS), .MIN_RST_PS(MIN_RST_PS)
) u_chk (
  .clk(clk), .rst(rst), .ps2_mode(ps2_mode), .ctl_q(ctl_q),
  .fdc_reset(fdc_reset), .ds_n(ds_n), .drq_oe(drq_oe), .fintr_oe(fintr_oe),
  .dack_gate(dack_gate), .tc_gate(tc_gate), .bus_rdata(bus_rdata)
);

// File: tb/fdc_out_ctl_test.sv
`timescale 1ns/1ps
module fdc_out_ctl_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h03F2;
  localparam int          HOLD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ps2_mode = 1'b0;
  logic        fdc_reset;
  logic [1:0]  ds_n, mtr_n;
  logic        drq_oe, fintr_oe, dack_gate, tc_gate;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_out_ctl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ps2_mode(ps2_mode), .fdc_reset(fdc_reset), .ds_n(ds_n), .mtr_n(mtr_n),
    .drq_oe(drq_oe), .fintr_oe(fintr_oe), .dack_gate(dack_gate), .tc_gate(tc_gate)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called just after a falling edge; returns one falling edge later.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [1:0] exp_ds(input logic [7:0] v);
    return {v[1:0] != 2'd1, v[1:0] != 2'd0};
  endfunction

  function automatic logic [3:0] gates();
    return {drq_oe, fintr_oe, dack_gate, tc_gate};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n;
    logic [1:0] ds_at;
    repeat (3) @(negedge clk);
    chk("R9 gates closed in hw reset (AT)", 16'(gates()), 16'h0);
    chk("R1 fdc_reset in hw reset", 16'(fdc_reset), 16'h1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fdc_reset after reset", 16'(fdc_reset), 16'h1);
    chk("R1 ds_n after reset", 16'(ds_n), 16'h2);
    chk("R1 mtr_n after reset", 16'(mtr_n), 16'h3);
    rd(BASE, r);
    chk("R1 register after reset", 16'(r), 16'h00);
    rd(16'h0000, r);
    chk("R2 rdata idle is zero", 16'(r), 16'h00);

    // Exhaustive write sweep, mode from bit 7.
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      ps2_mode = vb[7];
      wr(BASE, vb);
      @(negedge clk);
      chk("R4 drive select decode", 16'(ds_n), 16'(exp_ds(vb)));
      chk("R5 motor outputs", 16'(mtr_n), 16'({!vb[5], !vb[4]}));
      chk(vb[7] ? "R10 ps2 gates open" : "R9 AT gates follow bit3",
          16'(gates()), (vb[7] | vb[3]) ? 16'hF : 16'h0);
      if (!vb[2]) chk("R6 reset asserted by bit2=0", 16'(fdc_reset), 16'h1);
      rd(BASE, r);
      chk("R2 readback masked", 16'(r), 16'(vb & 8'h3F));
    end
    ps2_mode = 1'b0;

    wr(BASE, 8'h1C); @(negedge clk);
    chk("R5 0x1C ds_n", 16'(ds_n), 16'h2);
    chk("R5 0x1C mtr_n", 16'(mtr_n), 16'h2);
    wr(BASE, 8'h2D); @(negedge clk);
    chk("R5 0x2D ds_n", 16'(ds_n), 16'h1);
    chk("R5 0x2D mtr_n", 16'(mtr_n), 16'h1);

    wr(16'h03F3, 8'h00);
    wr(16'h07F2, 8'h00);
    wr(16'h03F0, 8'h00);
    @(negedge clk);
    rd(BASE, r);
    chk("R3 other address ignored (reg)", 16'(r), 16'h2D);
    chk("R3 other address ignored (ds_n)", 16'(ds_n), 16'h1);
    chk("R3 other address ignored (mtr_n)", 16'(mtr_n), 16'h1);

    repeat (15) @(negedge clk);
    chk("R6 reset released after bit2=1", 16'(fdc_reset), 16'h0);

    wr(BASE, 8'h29);
    repeat (30) @(negedge clk);
    chk("R6 reset held while bit2=0", 16'(fdc_reset), 16'h1);
    wr(BASE, 8'h2D);
    repeat (20) @(negedge clk);
    chk("R6 reset released", 16'(fdc_reset), 16'h0);

    // Single-cycle zero on bit 2.
    wr(BASE, 8'h29);
    wr(BASE, 8'h2D);
    ds_at = ds_n;
    n = 0;
    while (fdc_reset && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R7 stretched reset width", 16'(n), 16'(HOLD + 1));
    chk("R8 ds_n during soft reset", 16'(ds_at), 16'h1);
    chk("R8 mtr_n after soft reset", 16'(mtr_n), 16'h1);
    rd(BASE, r);
    chk("R8 register untouched by soft reset", 16'(r), 16'h2D);

    // Hardware reset in each mode.
    ps2_mode = 1'b1;
    wr(BASE, 8'h0C);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 gates open in hw reset (ps2)", 16'(gates()), 16'hF);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 gates open after hw reset", 16'(gates()), 16'hF);
    rd(BASE, r);
    chk("R10 bit3 cleared by hw reset", 16'(r), 16'h00);

    ps2_mode = 1'b0;
    wr(BASE, 8'h08); @(negedge clk);
    chk("R9 AT gates open with bit3", 16'(gates()), 16'hF);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 AT gates closed in hw reset", 16'(gates()), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ds_n after second reset", 16'(ds_n), 16'h2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule